// File: doc/BRIEF.md
# Power Sequence Command Executor

This block is a small hardware sequencer that brings a chip's power domains up or down by walking a table of entries. The table sits outside the block and is read one entry at a time through a synchronous fetch port. Each entry has three bitmask filters: one for chip revision, one for fabrication variant and one for host interface. The block compares each filter against a one-hot selector input, and only entries that pass all three are executed.

An executed entry performs one command on a simple synchronous register bus: a plain read, a masked read-modify-write, a poll that reads until masked bits match, or a timed wait in microseconds or milliseconds. An end entry stops the walk with success. A poll that never matches stops the walk with failure, and so does running past the last table slot. When the walk stops, `done` rises and `ok` gives the result.

Top module: `pwrseq_exec`

## Requirements
- R1: A table entry is 56 bits wide, laid out as offset [55:40], revision mask [39:32], fab mask [31:28], interface mask [27:24], address-space selector [23:20], command [19:16], bit mask [15:8] and value [7:0]. An entry runs only when each of its three masks shares at least one set bit with `rev_sel`, `fab_sel` and `intf_sel` respectively. Any other entry is skipped with no bus access.
- R2: Command 0 (read) performs one bus read at the entry's selector and offset and loads `rd_val` with the read data ANDed with the bit mask. It performs no write.
- R3: Command 1 (masked write) reads the register, then writes `(old & ~mask) | (value & mask)` to the same address.
- R4: Command 2 (poll) keeps reading the register until `(data & mask) == (value & mask)`, then moves on to the next entry.
- R5: A poll that gets no match in `POLL_LIMIT` reads stops the sequence with `done`=1 and `ok`=0, and makes no further accesses.
- R6: Command 3 (wait) takes its count from the offset field. Value bit 0 selects the unit: 0 is one microsecond of `US_CYC` clocks, 1 is `US_PER_MS` microseconds. The next access comes exactly count × unit clocks later than it would with a count of zero.
- R7: Command 4 (end) stops the walk with `done`=1, `ok`=1 and `busy`=0. No later entry is executed.
- R8: A `start` pulse received while `busy` is high has no effect on the running sequence.
- R9: `reg_re` and `reg_we` are never high together. A strobe, with its address, selector and write data, is held unchanged until a cycle in which `reg_rdy` is high.
- R10: If the last table slot is passed without an executed end entry, the walk stops with `done`=1 and `ok`=0.
- R11: After reset `busy`, `done`, `ok`, `reg_re`, `reg_we` and `rd_val` are all zero, and the block stays idle until `start` arrives.
- R12: Command codes 5 to 15 are skipped like filtered entries, with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking the table from slot 0 |
| rev_sel | input | 8 | One-hot current chip revision |
| fab_sel | input | 4 | One-hot current fab variant |
| intf_sel | input | 4 | One-hot current host interface |
| tbl_addr | output | IW | Table slot being fetched |
| tbl_data | input | 56 | Entry returned one clock after `tbl_addr` |
| reg_base | output | 4 | Address-space selector of the access |
| reg_addr | output | 16 | Register offset of the access |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Write strobe |
| reg_re | output | 1 | Read strobe |
| reg_rdata | input | 8 | Read data, valid with `reg_rdy` |
| reg_rdy | input | 1 | Completes the pending access |
| rd_val | output | 8 | Masked result of the last read command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| ok | output | 1 | Finished at an end entry |

## Verification
Some properties are checked on every cycle: the bus strobes never overlap, each strobe is held steady until it is acknowledged, `done` never coexists with activity, the wait counter never runs out while it is active, and the timer's completion pulse lasts one cycle. Other behaviours can only be shown by the bench scenarios against its reference walk of the table. These are the choice of which entries are skipped, the merged write values, the number of reads a poll makes before it matches or times out, the exact length of microsecond and millisecond waits, and the fact that a second `start` is ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int ENT_W = 56;

  typedef struct packed {
    logic [15:0] off;
    logic [7:0]  rev_m;
    logic [3:0]  fab_m;
    logic [3:0]  intf_m;
    logic [3:0]  base;
    logic [3:0]  cmd;
    logic [7:0]  bmask;
    logic [7:0]  val;
  } seq_ent_t;

  localparam logic [3:0] OP_READ  = 4'd0;
  localparam logic [3:0] OP_WRITE = 4'd1;
  localparam logic [3:0] OP_POLL  = 4'd2;
  localparam logic [3:0] OP_WAIT  = 4'd3;
  localparam logic [3:0] OP_STOP  = 4'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DEC, ST_RD, ST_WR, ST_WAIT
  } seq_st_t;
endpackage

// File: rtl/pwrseq_filter.sv
module pwrseq_filter #(
  parameter int REV_W  = 8,
  parameter int FAB_W  = 4,
  parameter int INTF_W = 4
) (
  input  logic [REV_W-1:0]  rev_m,
  input  logic [FAB_W-1:0]  fab_m,
  input  logic [INTF_W-1:0] intf_m,
  input  logic [REV_W-1:0]  rev_sel,
  input  logic [FAB_W-1:0]  fab_sel,
  input  logic [INTF_W-1:0] intf_sel,
  output logic              hit
);
  always_comb begin
    hit = (|(rev_m & rev_sel)) && (|(fab_m & fab_sel)) && (|(intf_m & intf_sel));
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int US_CYC    = 50,
  parameter int US_PER_MS = 1000,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] cnt,
  input  logic             unit_ms,
  output logic             fire
);
  localparam int PW = $clog2(US_CYC + 1);
  localparam int SW = $clog2(US_PER_MS + 1);

  logic [PW-1:0]    pre;
  logic [SW-1:0]    sub;
  logic [CNT_W-1:0] remain;
  logic             active;
  logic             ms_q;
  logic             tick;
  logic             unit_tick;

  assign tick      = active && (pre == PW'(US_CYC - 1));
  assign unit_tick = tick && (!ms_q || (sub == SW'(US_PER_MS - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      sub    <= '0;
      remain <= '0;
      active <= 1'b0;
      ms_q   <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (go) begin
        remain <= cnt;
        pre    <= '0;
        sub    <= '0;
        ms_q   <= unit_ms;
        active <= (cnt != '0);
        fire   <= (cnt == '0);
      end else if (active) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick && ms_q)
          sub <= (sub == SW'(US_PER_MS - 1)) ? '0 : sub + 1'b1;
        if (unit_tick) begin
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) begin
            active <= 1'b0;
            fire   <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  remain_live_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (remain != '0));

  // R6
  fire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/pwrseq_exec.sv
module pwrseq_exec
  import pwrseq_pkg::*;
#(
  parameter int TBL_DEPTH  = 16,
  parameter int US_CYC     = 50,
  parameter int US_PER_MS  = 1000,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          start,
  input  logic [7:0]                                    rev_sel,
  input  logic [3:0]                                    fab_sel,
  input  logic [3:0]                                    intf_sel,
  output logic [((TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1)-1:0] tbl_addr,
  input  logic [55:0]                                   tbl_data,
  output logic [3:0]                                    reg_base,
  output logic [15:0]                                   reg_addr,
  output logic [7:0]                                    reg_wdata,
  output logic                                          reg_we,
  output logic                                          reg_re,
  input  logic [7:0]                                    reg_rdata,
  input  logic                                          reg_rdy,
  output logic [7:0]                                    rd_val,
  output logic                                          busy,
  output logic                                          done,
  output logic                                          ok
);
  localparam int IW  = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  seq_st_t        st;
  seq_ent_t       ent;
  seq_ent_t       nxt;
  logic [IW-1:0]  idx;
  logic [PCW-1:0] tries;
  logic           hit;
  logic           last_slot;
  logic           tmr_go;
  logic           tmr_fire;
  logic           poll_match;

  assign nxt        = seq_ent_t'(tbl_data);
  assign tbl_addr   = idx;
  assign reg_addr   = ent.off;
  assign reg_base   = ent.base;
  assign last_slot  = (idx == IW'(TBL_DEPTH - 1));
  assign tmr_go     = (st == ST_DEC) && hit && (nxt.cmd == OP_WAIT);
  assign poll_match = ((reg_rdata & ent.bmask) == (ent.val & ent.bmask));

  pwrseq_filter #(.REV_W(8), .FAB_W(4), .INTF_W(4)) u_filter (
    .rev_m   (nxt.rev_m),
    .fab_m   (nxt.fab_m),
    .intf_m  (nxt.intf_m),
    .rev_sel (rev_sel),
    .fab_sel (fab_sel),
    .intf_sel(intf_sel),
    .hit     (hit)
  );

  pwrseq_timer #(.US_CYC(US_CYC), .US_PER_MS(US_PER_MS), .CNT_W(16)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .go     (tmr_go),
    .cnt    (nxt.off),
    .unit_ms(nxt.val[0]),
    .fire   (tmr_fire)
  );

  // step: move to the next slot, or fail when the table is exhausted
  logic step;
  always_comb begin
    step = 1'b0;
    case (st)
      ST_DEC:  step = !hit || (nxt.cmd > OP_STOP);
      ST_RD:   step = reg_rdy && ((ent.cmd == OP_READ) ||
                                  ((ent.cmd == OP_POLL) && poll_match));
      ST_WR:   step = reg_rdy;
      ST_WAIT: step = tmr_fire;
      default: step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ent       <= '0;
      idx       <= '0;
      tries     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      reg_re    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      rd_val    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          idx  <= '0;
          st   <= ST_FETCH;
          busy <= 1'b1;
          done <= 1'b0;
          ok   <= 1'b0;
        end
        ST_FETCH: st <= ST_DEC;
        ST_DEC: begin
          ent   <= nxt;
          tries <= '0;
          if (hit) begin
            case (nxt.cmd)
              OP_READ, OP_WRITE, OP_POLL: begin
                reg_re <= 1'b1;
                st     <= ST_RD;
              end
              OP_WAIT: st <= ST_WAIT;
              OP_STOP: begin
                st   <= ST_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
                ok   <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_RD: if (reg_rdy) begin
          if (ent.cmd == OP_READ) begin
            rd_val <= reg_rdata & ent.bmask;
            reg_re <= 1'b0;
          end else if (ent.cmd == OP_WRITE) begin
            reg_re    <= 1'b0;
            reg_we    <= 1'b1;
            reg_wdata <= (reg_rdata & ~ent.bmask) | (ent.val & ent.bmask);
            st        <= ST_WR;
          end else if (poll_match) begin
            reg_re <= 1'b0;
          end else if (tries == PCW'(POLL_LIMIT - 1)) begin
            reg_re <= 1'b0;
            st     <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
            ok     <= 1'b0;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        ST_WR: if (reg_rdy) reg_we <= 1'b0;
        default: ;
      endcase

      if (step) begin
        if (last_slot) begin
          st   <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
          ok   <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          st  <= ST_FETCH;
        end
      end
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_re && reg_we));

  // R9
  re_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !reg_rdy) |=> (reg_re && $stable(reg_addr) && $stable(reg_base)));

  // R9
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_rdy) |=> (reg_we && $stable(reg_addr) && $stable(reg_wdata)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !reg_re && !reg_we));

  // R7
  ok_done_chk: assert property (@(posedge clk) disable iff (rst)
    ok |-> done);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);
endmodule

// File: tb/sim_pwrseq_exec.sv
module sim_pwrseq_exec;
  localparam int CLK_NS  = 10;
  localparam int DEPTH   = 16;
  localparam int UCYC    = 4;
  localparam int UPMS    = 1000;
  localparam int PLIM    = 8;
  localparam int WD_CYC  = 150000;
  localparam logic [7:0] POLL_OFF = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  rev_sel = 8'b0000_0100;
  logic [3:0]  fab_sel = 4'b0001;
  logic [3:0]  intf_sel = 4'b0010;
  logic [3:0]  tbl_addr;
  logic [55:0] tbl_data;
  logic [3:0]  reg_base;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we, reg_re;
  logic [7:0]  reg_rdata = '0;
  logic        reg_rdy = 1'b0;
  logic [7:0]  rd_val;
  logic        busy, done, ok;

  always #(CLK_NS/2) clk = ~clk;

  pwrseq_exec #(.TBL_DEPTH(DEPTH), .US_CYC(UCYC), .US_PER_MS(UPMS), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst(rst), .start(start), .rev_sel(rev_sel), .fab_sel(fab_sel),
    .intf_sel(intf_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .reg_base(reg_base), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy),
    .rd_val(rd_val), .busy(busy), .done(done), .ok(ok)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit summarized = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_CYC) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD_CYC);
      summary();
    end
  end

  // table storage with one-clock read latency
  logic [55:0] tbl [DEPTH];
  always @(posedge clk) tbl_data <= tbl[tbl_addr];

  // peripheral register image and poll target behaviour
  logic [7:0] regs [256];
  int poll_n = 0;
  int poll_after = 0;
  logic [7:0] poll_hit = '0;
  logic [7:0] poll_miss = '0;
  int bw = 0;

  // reference expectations
  logic [28:0] exp_q[$];
  int          wr_cyc[$];
  bit          exp_ok;
  logic [7:0]  exp_rd = '0;

  // bus responder and per-clock protocol checks
  int wcnt = 0;
  bit pend = 0;
  logic p_re, p_we;
  logic [15:0] p_addr;
  logic [3:0]  p_base;
  logic [7:0]  p_wd;
  always @(negedge clk) begin
    if (!rst) begin
      chk(!(reg_re && reg_we), "R9", "strobes overlap", {reg_re, reg_we}, 0);
      if (!busy) chk(!reg_re && !reg_we, "R11", "strobe while idle", {reg_re, reg_we}, 0);
      if (pend)
        chk(reg_re == p_re && reg_we == p_we && reg_addr == p_addr && reg_base == p_base &&
            (!p_we || reg_wdata == p_wd), "R9", "strobe not held",
            {reg_re, reg_we, reg_base, reg_addr}, {p_re, p_we, p_base, p_addr});
      if (reg_re || reg_we) begin
        if (wcnt >= bw) begin
          logic [7:0] d;
          logic [28:0] t;
          reg_rdy = 1'b1;
          wcnt = 0;
          pend = 0;
          if (reg_we) begin
            d = reg_wdata;
            regs[reg_addr[7:0]] = reg_wdata;
            wr_cyc.push_back(cyc);
          end else if (reg_addr[7:0] == POLL_OFF) begin
            d = (poll_n >= poll_after) ? poll_hit : poll_miss;
            poll_n++;
          end else begin
            d = regs[reg_addr[7:0]];
          end
          reg_rdata = d;
          t = {reg_we, reg_base, reg_addr, d};
          if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected bus access", t, 0);
          end else begin
            logic [28:0] e;
            e = exp_q.pop_front();
            chk(t == e, "R1", "bus access {we,base,addr,data}", t, e);
          end
        end else begin
          reg_rdy = 1'b0;
          wcnt++;
          pend = 1;
          p_re = reg_re; p_we = reg_we; p_addr = reg_addr; p_base = reg_base; p_wd = reg_wdata;
        end
      end else begin
        reg_rdy = 1'b0;
        wcnt = 0;
        pend = 0;
      end
    end
  end

  function automatic logic [55:0] mk(input logic [15:0] off, input logic [7:0] rv,
                                     input logic [3:0] fb, input logic [3:0] it,
                                     input logic [3:0] bs, input logic [3:0] cm,
                                     input logic [7:0] m, input logic [7:0] v);
    return {off, rv, fb, it, bs, cm, m, v};
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < DEPTH; i++) tbl[i] = '0;
  endtask

  // behavioural walk of the table producing the expected bus traffic
  task automatic build_model();
    logic [7:0] img [256];
    for (int i = 0; i < 256; i++) img[i] = regs[i];
    exp_q.delete();
    exp_ok = 0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [15:0] off; logic [7:0] rv, m, v, d; logic [3:0] fb, it, bs, cm;
      {off, rv, fb, it, bs, cm, m, v} = tbl[i];
      if ((rv & rev_sel) == 0 || (fb & fab_sel) == 0 || (it & intf_sel) == 0) continue;
      if (cm == 4'd0) begin
        d = img[off[7:0]];
        exp_q.push_back({1'b0, bs, off, d});
        exp_rd = d & m;
      end else if (cm == 4'd1) begin
        d = img[off[7:0]];
        exp_q.push_back({1'b0, bs, off, d});
        d = (d & ~m) | (v & m);
        img[off[7:0]] = d;
        exp_q.push_back({1'b1, bs, off, d});
      end else if (cm == 4'd2) begin
        bit fin = 0;
        for (int a = 0; a < PLIM && !fin; a++) begin
          d = (a >= poll_after) ? poll_hit : poll_miss;
          exp_q.push_back({1'b0, bs, off, d});
          if ((d & m) == (v & m)) fin = 1;
        end
        if (!fin) begin exp_ok = 0; return; end
      end else if (cm == 4'd4) begin
        exp_ok = 1;
        return;
      end
    end
    exp_ok = 0;
  endtask

  task automatic run_seq(input string req, input int kick_at);
    int n = 0;
    poll_n = 0;
    wr_cyc.delete();
    build_model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      @(negedge clk);
      n++;
      start = (kick_at > 0 && n == kick_at);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(done && !busy, req, "done/busy at finish", {done, busy}, 2'b10);
    chk(ok == exp_ok, req, "ok status", ok, exp_ok);
    chk(exp_q.size() == 0, req, "missing bus accesses", exp_q.size(), 0);
    chk(rd_val == exp_rd, "R2", "rd_val", rd_val, exp_rd);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = '0;
    clear_tbl();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !ok, "R11", "status after reset", {busy, done, ok}, 0);
    chk(!reg_re && !reg_we && rd_val == 0, "R11", "bus after reset", {reg_re, reg_we, rd_val}, 0);
    repeat (5) @(negedge clk);
    chk(!busy, "R11", "idle without start", busy, 0);

    // mixed table with filtering, unknown codes, poll, wait states (R1 R2 R3 R4 R7 R9 R12)
    bw = 2;
    regs[8'h10] = 8'hA5;
    regs[8'h11] = 8'hC9;
    poll_after = 3; poll_hit = 8'h81; poll_miss = 8'h01;
    clear_tbl();
    tbl[0] = mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'h1, 4'd0, 8'hF0, 8'h00);
    tbl[1] = mk(16'h0011, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'h0F, 8'h36);
    tbl[2] = mk(16'h0012, 8'h08, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h11);
    tbl[3] = mk(16'h0018, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd7, 8'hFF, 8'h11);
    tbl[4] = mk(16'h0013, 8'hFF, 4'h2, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h22);
    tbl[5] = mk(16'h0014, 8'hFF, 4'hF, 4'h5, 4'h0, 4'd1, 8'hFF, 8'h33);
    tbl[6] = mk(16'h0020, 8'hFF, 4'hF, 4'hF, 4'h2, 4'd2, 8'h81, 8'h81);
    tbl[7] = mk(16'h0015, 8'hFF, 4'hF, 4'hF, 4'h3, 4'd1, 8'hFF, 8'h5A);
    tbl[8] = mk(16'h0000, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd4, 8'h00, 8'h00);
    tbl[9] = mk(16'h0016, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h77);
    run_seq("R7", 0);
    chk(regs[8'h11] == 8'hC6, "R3", "merged write", regs[8'h11], 8'hC6);
    chk(regs[8'h12] == 8'h00 && regs[8'h13] == 8'h00 && regs[8'h14] == 8'h00, "R1",
        "filtered entries untouched", {regs[8'h12], regs[8'h13], regs[8'h14]}, 0);
    chk(regs[8'h18] == 8'h00, "R12", "unknown code untouched", regs[8'h18], 0);
    chk(poll_n == 4, "R4", "poll read count", poll_n, 4);
    chk(regs[8'h16] == 8'h00, "R7", "entry after end untouched", regs[8'h16], 0);

    // waits in both units, with a stray start during the run (R6 R8)
    bw = 0;
    clear_tbl();
    tbl[0] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h01);
    tbl[1] = mk(16'h0000, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h00);
    tbl[2] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h02);
    tbl[3] = mk(16'h0003, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h00);
    tbl[4] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h03);
    tbl[5] = mk(16'h0002, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h01);
    tbl[6] = mk(16'h0030, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h04);
    tbl[7] = mk(16'h0000, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd4, 8'h00, 8'h00);
    run_seq("R8", 3000);
    chk(wr_cyc.size() == 4, "R8", "write count", wr_cyc.size(), 4);
    if (wr_cyc.size() == 4) begin
      // zero-count gap is 7 clocks for write, wait, write
      chk(wr_cyc[1] - wr_cyc[0] == 7, "R6", "zero wait gap", wr_cyc[1] - wr_cyc[0], 7);
      chk(wr_cyc[2] - wr_cyc[1] == 3*UCYC + 7, "R6", "3 us gap",
          wr_cyc[2] - wr_cyc[1], 3*UCYC + 7);
      chk(wr_cyc[3] - wr_cyc[2] == 2*UPMS*UCYC + 7, "R6", "2 ms gap",
          wr_cyc[3] - wr_cyc[2], 2*UPMS*UCYC + 7);
    end
    chk(regs[8'h30] == 8'h04, "R8", "final write value", regs[8'h30], 8'h04);

    // poll timeout (R5)
    bw = 1;
    poll_after = 1000; poll_miss = 8'h00;
    clear_tbl();
    tbl[0] = mk(16'h0020, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd2, 8'h01, 8'h01);
    tbl[1] = mk(16'h0017, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h99);
    tbl[2] = mk(16'h0000, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd4, 8'h00, 8'h00);
    run_seq("R5", 0);
    chk(poll_n == PLIM, "R5", "timeout read count", poll_n, PLIM);
    chk(regs[8'h17] == 8'h00, "R5", "no access after timeout", regs[8'h17], 0);

    // no entry ever matches: run off the end of the table (R10)
    clear_tbl();
    run_seq("R10", 0);
    chk(!ok, "R10", "table exhausted fails", ok, 0);

    summary();
  end
endmodule